// File: doc/BRIEF.md
# Qualified performance event counter

This block is one performance monitor counter together with its local control register. Each clock cycle it looks at one line out of a bank of up to 128 event inputs. When that line is high and no freeze qualifier applies, the counter goes up by one. The freeze qualifiers are an unconditional stop, stops that depend on the current privilege level (`pr_i`), and stops that depend on a process-mark input (`pmm_i`). These let software count events only for chosen code or chosen processes.

An overflow flag can be enabled in the control register. When enabled, the flag follows the counter's top bit, so downstream logic sees a level while the counter sits in its upper half. Software reaches the block through a small synchronous read/write port. The control register has two addresses: a supervisor address that can be written and a user address that can only be read. The counter value has its own supervisor address. A write to a supervisor address made in user state has no effect and raises a one-cycle error pulse.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, and both `ovf_o` and `priv_err_o` are low.
- R2: The control word has FC at bit 31, FCS at 30, FCU at 29, FCM1 at 28, FCM0 at 27, CE at 26 and the event select at bits 22:16. All other bits are not stored and read as 0, so writing all ones reads back 0xFC7F0000.
- R3: The counter goes up by exactly one at a clock edge when `evt_i[select]` is high and no freeze applies. It holds when the selected line is low, whatever the other lines do.
- R4: While FC is 1 the counter never increments.
- R5: FCS=1 blocks increments while `pr_i`=0. FCU=1 blocks increments while `pr_i`=1.
- R6: FCM1=1 blocks increments while `pmm_i`=1. FCM0=1 blocks increments while `pmm_i`=0.
- R7: `ovf_o` equals CE AND the counter's most significant bit. It is therefore always 0 when CE is 0, and it is not a wrap event.
- R8: Address 1 (user alias) returns the control word in either privilege state. Writes to address 1 are ignored.
- R9: Address 2 reads and writes the counter. A write there takes priority over an increment in the same cycle.
- R10: Addresses 0 and 2 are supervisor-only. When `pr_i`=1, a write to either is ignored, `priv_err_o` is high for exactly the next cycle, and reads of either return 0. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pr_i | input | 1 | Privilege level: 1 = user, 0 = supervisor |
| pmm_i | input | 1 | Process-mark qualifier |
| evt_i | input | EVT_N | Event input lines |
| addr_i | input | 2 | Register address: 0 control (supervisor), 1 control (user, read-only), 2 counter |
| wr_en_i | input | 1 | Write strobe for `wdata_i` at `addr_i` |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| ovf_o | output | 1 | Overflow condition level |
| priv_err_o | output | 1 | One-cycle pulse after a supervisor write attempted in user state |

## Verification
The condition hardest to reach from the ports is the overflow level: counting up from zero would take billions of events before the top bit sets. The bench therefore loads values just below the midpoint through the counter address and then lets a few qualified events carry the counter across it, with CE both set and clear. It also includes random counter writes, which put the top bit high about half the time. Random privilege, mark and event patterns run together with random control words, so every freeze qualifier meets both levels of its input.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned SEL_W  = 7;
  localparam int unsigned SEL_LO = 16;
  localparam int unsigned FC_B   = 31;
  localparam int unsigned FCS_B  = 30;
  localparam int unsigned FCU_B  = 29;
  localparam int unsigned FCM1_B = 28;
  localparam int unsigned FCM0_B = 27;
  localparam int unsigned CE_B   = 26;

  typedef enum logic [1:0] {
    A_CTRL_SUP = 2'd0,
    A_CTRL_USR = 2'd1,
    A_COUNT    = 2'd2,
    A_NONE     = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             fc;
    logic             fcs;
    logic             fcu;
    logic             fcm1;
    logic             fcm0;
    logic             ce;
    logic [SEL_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/qec_ctrl_reg.sv
module qec_ctrl_reg
  import qec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  ctrl_t wctrl_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wctrl_i;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/qec_freeze_qual.sv
module qec_freeze_qual
  import qec_pkg::*;
#(
  parameter int unsigned EVT_N = 128
) (
  input  logic             fc_i,
  input  logic             fcs_i,
  input  logic             fcu_i,
  input  logic             fcm1_i,
  input  logic             fcm0_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pr_i,
  input  logic             pmm_i,
  input  logic [EVT_N-1:0] evt_i,
  output logic             inc_o
);
  localparam int unsigned SLOTS = 2 ** SEL_W;

  logic [SLOTS-1:0] evt_pad;
  logic             frozen;

  generate
    if (EVT_N < SLOTS) begin : g_pad
      assign evt_pad = {{(SLOTS-EVT_N){1'b0}}, evt_i};
    end else begin : g_full
      assign evt_pad = evt_i[SLOTS-1:0];
    end
  endgenerate

  // any one qualifier stops the count
  assign frozen = fc_i
                | (fcs_i  & ~pr_i)
                | (fcu_i  &  pr_i)
                | (fcm1_i &  pmm_i)
                | (fcm0_i & ~pmm_i);

  assign inc_o = evt_pad[sel_i] & ~frozen;

  initial begin
    a_evt_n_fits: assert (EVT_N >= 1 && EVT_N <= SLOTS);
  end
endmodule

// File: rtl/qec_counter.sv
module qec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic             inc_i,
  input  logic             ce_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_data_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ce_i & cnt_q[CNT_W-1];

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_q));

  p_load_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_data_i)));
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int unsigned EVT_N = 128,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pr_i,
  input  logic             pmm_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             ovf_o,
  output logic             priv_err_o
);
  reg_addr_e        addr;
  ctrl_t            ctrl, wctrl;
  logic             sup_addr, sup_ok;
  logic             ctrl_wr, cnt_wr, inc;
  logic             err_q;
  logic [REG_W-1:0] ctrl_word;
  logic [CNT_W-1:0] cnt;

  assign addr     = reg_addr_e'(addr_i);
  assign sup_addr = (addr == A_CTRL_SUP) || (addr == A_COUNT);
  assign sup_ok   = wr_en_i & ~pr_i;
  assign ctrl_wr  = sup_ok & (addr == A_CTRL_SUP);
  assign cnt_wr   = sup_ok & (addr == A_COUNT);

  assign wctrl = '{fc:   wdata_i[FC_B],   fcs:  wdata_i[FCS_B], fcu: wdata_i[FCU_B],
                   fcm1: wdata_i[FCM1_B], fcm0: wdata_i[FCM0_B], ce: wdata_i[CE_B],
                   sel:  wdata_i[SEL_LO +: SEL_W]};

  qec_ctrl_reg i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wctrl_i (wctrl),
    .ctrl_o  (ctrl)
  );

  qec_freeze_qual #(.EVT_N(EVT_N)) i_qual (
    .fc_i   (ctrl.fc),
    .fcs_i  (ctrl.fcs),
    .fcu_i  (ctrl.fcu),
    .fcm1_i (ctrl.fcm1),
    .fcm0_i (ctrl.fcm0),
    .sel_i  (ctrl.sel),
    .pr_i   (pr_i),
    .pmm_i  (pmm_i),
    .evt_i  (evt_i),
    .inc_o  (inc)
  );

  qec_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (cnt_wr),
    .ld_data_i (wdata_i[CNT_W-1:0]),
    .inc_i     (inc),
    .ce_i      (ctrl.ce),
    .cnt_o     (cnt),
    .ovf_o     (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_en_i & pr_i & sup_addr;
  end
  assign priv_err_o = err_q;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[FC_B]   = ctrl.fc;
    ctrl_word[FCS_B]  = ctrl.fcs;
    ctrl_word[FCU_B]  = ctrl.fcu;
    ctrl_word[FCM1_B] = ctrl.fcm1;
    ctrl_word[FCM0_B] = ctrl.fcm0;
    ctrl_word[CE_B]   = ctrl.ce;
    ctrl_word[SEL_LO +: SEL_W] = ctrl.sel;
  end

  always_comb begin
    unique case (addr)
      A_CTRL_SUP: rdata_o = pr_i ? '0 : ctrl_word;
      A_CTRL_USR: rdata_o = ctrl_word;
      A_COUNT:    rdata_o = pr_i ? '0 : REG_W'(cnt);
      default:    rdata_o = '0;
    endcase
  end

  initial begin
    a_cnt_w_fits: assert (CNT_W >= 2 && CNT_W <= REG_W);
  end

  p_fc_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.fc && !cnt_wr) |=> $stable(cnt));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.ce |-> !ovf_o);

  p_user_alias_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == A_CTRL_USR) |=> $stable(ctrl));

  p_priv_reject_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pr_i && sup_addr) |=> (priv_err_o && $stable(ctrl)));

  p_err_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && pr_i && sup_addr) |=> !priv_err_o);
endmodule

// File: tb/test_qual_event_counter.sv
module test_qual_event_counter;
  localparam logic [31:0] CMASK = 32'hFC7F_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pr = 1'b0, pmm = 1'b0, wr = 1'b0;
  logic [127:0] evt = '0;
  logic [1:0]   addr = 2'd3;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         ovf, perr;

  int unsigned  n_chk = 0, n_bad = 0;
  logic [31:0]  m_ctl = '0, m_cnt = '0;
  logic         m_err = 1'b0;

  always #2.5 clk = ~clk;

  qual_event_counter i_qual_event_counter (
    .clk_i(clk), .rst_ni(rst_n), .pr_i(pr), .pmm_i(pmm), .evt_i(evt),
    .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .ovf_o(ovf), .priv_err_o(perr)
  );

  function automatic logic frz(logic [31:0] c, logic p, logic m);
    return c[31] | (c[30] & ~p) | (c[29] & p) | (c[28] & m) | (c[27] & ~m);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic p, logic m, logic [127:0] e, logic [1:0] a, logic w, logic [31:0] d);
    pr = p; pmm = m; evt = e; addr = a; wr = w; wdata = d;
  endtask

  // one edge: update model from current inputs, then check outputs at negedge
  task automatic tick();
    logic [31:0] nc = m_ctl, nn = m_cnt;
    logic        ne = 1'b0;
    if (wr && pr && (addr == 2'd0 || addr == 2'd2)) ne = 1'b1;
    if (wr && !pr && addr == 2'd0) nc = wdata & CMASK;
    if (wr && !pr && addr == 2'd2) nn = wdata;
    else if (evt[m_ctl[22:16]] && !frz(m_ctl, pr, pmm)) nn = m_cnt + 1;
    @(posedge clk);
    m_ctl = nc; m_cnt = nn; m_err = ne;
    @(negedge clk);
    chk("R7 ovf", {31'd0, ovf}, {31'd0, m_ctl[26] & m_cnt[31]});
    chk("R10 priv_err", {31'd0, perr}, {31'd0, m_err});
  endtask

  task automatic rd(logic [1:0] a, logic p, logic [31:0] exp, string tag);
    drive(p, 1'b0, '0, a, 1'b0, '0);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    drive(1'b0, 1'b0, '0, a, 1'b1, d);
    tick();
  endtask

  task automatic run(logic p, logic m, logic [127:0] e, int n);
    for (int i = 0; i < n; i++) begin
      drive(p, m, e, 2'd3, 1'b0, '0);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset still held
    rd(2'd0, 1'b0, 32'd0, "R1 ctrl");
    rd(2'd2, 1'b0, 32'd0, "R1 count");
    chk("R1 ovf", {31'd0, ovf}, 32'd0);
    chk("R1 priv_err", {31'd0, perr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 layout and reserved bits
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 1'b0, 32'hFC7F_0000, "R2 all-ones");
    wr_reg(2'd0, 32'h0385_A5A5);
    rd(2'd0, 1'b0, 32'h0005_0000, "R2 sel only");

    // R3 selected line counts, others ignored
    run(1'b0, 1'b0, 128'h20, 3);
    rd(2'd2, 1'b0, 32'd3, "R3 count sel5");
    run(1'b0, 1'b0, ~128'h20, 4);
    rd(2'd2, 1'b0, 32'd3, "R3 other lines");

    // R4 FC
    wr_reg(2'd0, 32'h8005_0000);
    run(1'b0, 1'b1, '1, 4);
    rd(2'd2, 1'b0, 32'd3, "R4 fc freeze");

    // R5 FCS / FCU
    wr_reg(2'd0, 32'h4005_0000);
    run(1'b0, 1'b0, '1, 2);
    run(1'b1, 1'b0, '1, 2);
    rd(2'd2, 1'b0, 32'd5, "R5 fcs");
    wr_reg(2'd0, 32'h2005_0000);
    run(1'b1, 1'b0, '1, 3);
    run(1'b0, 1'b0, '1, 1);
    rd(2'd2, 1'b0, 32'd6, "R5 fcu");

    // R6 FCM1 / FCM0
    wr_reg(2'd0, 32'h1005_0000);
    run(1'b0, 1'b1, '1, 3);
    run(1'b0, 1'b0, '1, 2);
    rd(2'd2, 1'b0, 32'd8, "R6 fcm1");
    wr_reg(2'd0, 32'h0805_0000);
    run(1'b0, 1'b0, '1, 3);
    run(1'b0, 1'b1, '1, 1);
    rd(2'd2, 1'b0, 32'd9, "R6 fcm0");

    // R7 crossing the midpoint, with and without CE
    wr_reg(2'd0, 32'h047F_0000);
    wr_reg(2'd2, 32'h7FFF_FFFE);
    run(1'b0, 1'b0, 128'd1 << 127, 2);
    rd(2'd2, 1'b0, 32'h8000_0000, "R7 crossed");
    chk("R7 ovf set", {31'd0, ovf}, 32'd1);
    wr_reg(2'd0, 32'h007F_0000);
    chk("R7 ce clear", {31'd0, ovf}, 32'd0);

    // R8 user alias
    drive(1'b1, 1'b0, '0, 2'd1, 1'b1, 32'hFFFF_FFFF); tick();
    drive(1'b0, 1'b0, '0, 2'd1, 1'b1, 32'hFFFF_FFFF); tick();
    rd(2'd1, 1'b1, 32'h007F_0000, "R8 user alias");

    // R9 write beats increment
    drive(1'b0, 1'b0, '1, 2'd2, 1'b1, 32'h0000_1234); tick();
    rd(2'd2, 1'b0, 32'h0000_1234, "R9 priority");

    // R10 user-state supervisor writes
    drive(1'b1, 1'b0, '0, 2'd0, 1'b1, 32'hFFFF_FFFF); tick();
    drive(1'b1, 1'b0, '0, 2'd2, 1'b1, 32'h0); tick();
    drive(1'b1, 1'b0, '0, 2'd3, 1'b1, 32'h0); tick();
    rd(2'd0, 1'b1, 32'd0, "R10 sup read user");
    rd(2'd2, 1'b1, 32'd0, "R10 cnt read user");
    rd(2'd3, 1'b0, 32'd0, "R10 addr3");
    rd(2'd0, 1'b0, 32'h007F_0000, "R10 ctrl kept");
    rd(2'd2, 1'b0, 32'h0000_1234, "R10 cnt kept");

    // random mix, R3 R4 R5 R6 R9 via model
    for (int k = 0; k < 4000; k++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom % 4);
      d = $urandom;
      if (a == 2'd0 && ($urandom % 4) != 0) d[31] = 1'b0;
      drive(1'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
            a, ($urandom % 8) == 0, d);
      tick();
      if (k % 8 == 7) begin
        rd(2'd2, 1'b0, m_cnt, "R3 random count");
        rd(2'd1, 1'b1, m_ctl, "R8 random ctrl");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule